// File: doc/BRIEF.md
# Read-Only I2C Status Register Target

This block is an I2C target that answers read transfers only. A bus master can fetch up to sixteen byte-wide status registers from it. The register contents arrive on a wide parallel input, one byte per register. The block samples the open-drain SCL and SDA lines into the system clock domain and recognises Start and Stop conditions. It accepts a read addressed to its 7-bit device address. It then shifts register bytes out, most significant bit first, while an internal pointer steps forward each time the master acknowledges a byte.

There is no sub-address. Every Start, including a repeated Start, returns the pointer to register 0, so each transaction reads a prefix of the bank. The block never drives SDA high. It only asserts an output enable that pulls the line low, and it never stretches SCL.

Top module: `i2c_status_reader`

## Requirements
- R1: A Start condition (SDA falling while SCL is high) clears the read pointer to register 0 and starts address reception. This holds from any state, so a repeated Start in the middle of a read aborts that read.
- R2: The address byte is shifted in MSB first on eight SCL rising edges, and `sda_oe` stays 0 during those eight bits.
- R3: The received byte is a match when its upper seven bits equal `DEV_ADDR` and its LSB (the read bit) is 1. On a match, the target holds `sda_oe` at 1 through the ninth SCL pulse.
- R4: When the upper seven bits differ from `DEV_ADDR`, or the LSB is 0, the target does not acknowledge. It then keeps `sda_oe` at 0 until the next Start.
- R5: Register k is `reg_bank_i[8k+7:8k]`. Each register byte is sent MSB first over eight SCL pulses. During each pulse `sda_oe` is the inverse of the data bit, because 1 pulls SDA low.
- R6: When the master pulls SDA low on the ninth pulse after a data byte, the pointer advances and the next register's byte is sent.
- R7: When the master leaves SDA high on the ninth pulse after a data byte, the target releases SDA. It keeps `sda_oe` at 0 until the next Start.
- R8: The pointer stops at register NUM_REGS-1. A read that goes past that register repeats the last register's byte and does not wrap to register 0.
- R9: A Stop condition (SDA rising while SCL is high) sets `sda_oe` to 0 and returns the target to idle.
- R10: Both lines pass through a two-flop synchroniser. `sda_oe` changes only while the synchronised SCL is low, one system clock after a falling SCL edge is detected.
- R11: After reset, `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| reg_bank_i | input | 8*NUM_REGS | Register contents, register k at bits 8k+7..8k |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The hardest case to reach is a repeated Start arriving after the master has acknowledged a byte. At that point the target has already loaded the next byte and is driving its first bit, so the Start can only appear on the wire if that bit is a 1. The stimulus therefore picks register values whose MSBs are 1 at that point. It acknowledges two bytes, raises SDA while SCL is low, and then issues the Start. The reference model then expects register 0 to come back from the address that follows. Reading beyond the sixteenth byte and a Stop issued while the target is mid-byte are reached in the same way, by choosing bank values whose leading bit leaves the line free.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_TX,
      ST_TX_ACK
   } i2cr_state_t;
endpackage

// File: rtl/i2cr_sync.sv
// Multi-stage synchroniser with a one-cycle delayed copy for edge detection.
module i2cr_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic q_prev
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2cr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= {STAGES{RESET_VAL}};
         q_prev <= RESET_VAL;
      end else begin
         chain  <= {chain[STAGES-2:0], d};
         q_prev <= chain[STAGES-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cr_linemon.sv
// Synchronises both bus lines and derives clock edges and bus conditions.
module i2cr_linemon #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_p, sda_p;

   i2cr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s), .q_prev(scl_p)
   );

   i2cr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s), .q_prev(sda_p)
   );

   assign scl_rise  =  scl_s & ~scl_p;
   assign scl_fall  = ~scl_s &  scl_p;
   assign start_det =  scl_s &  scl_p &  sda_p & ~sda_s;
   assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_s;
endmodule

// File: rtl/i2cr_ptr.sv
// Saturating read pointer and byte selector.
module i2cr_ptr #(
   parameter int NUM_REGS = 16,
   localparam int PTR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int BANK_W  = 8 * NUM_REGS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   input  logic [BANK_W-1:0] bank,
   output logic [PTR_W-1:0]  ptr,
   output logic [7:0]        byte_o
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ptr <= '0;
      else if (clr)                  ptr <= '0;
      else if (inc && (ptr != LAST)) ptr <= ptr + 1'b1;
   end

   assign byte_o = bank[ptr*8 +: 8];
endmodule

// File: rtl/i2cr_engine.sv
// Bit-level protocol engine: address match, acknowledge and byte shifting.
module i2cr_engine
   import i2cr_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h3C
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sda_s,
   input  logic        scl_rise,
   input  logic        scl_fall,
   input  logic        start_det,
   input  logic        stop_det,
   input  logic [7:0]  tx_byte,
   output logic        ptr_inc,
   output logic        sda_oe,
   output i2cr_state_t state
);
   logic [7:0] shreg;
   logic [3:0] bitcnt;
   logic       acked;

   assign ptr_inc = (state == ST_TX_ACK) && scl_rise && !sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         sda_oe <= 1'b0;
         shreg  <= '0;
         bitcnt <= '0;
         acked  <= 1'b0;
      end else if (start_det) begin
         state  <= ST_ADDR;
         sda_oe <= 1'b0;
         shreg  <= '0;
         bitcnt <= '0;
         acked  <= 1'b0;
      end else if (stop_det) begin
         state  <= ST_IDLE;
         sda_oe <= 1'b0;
      end else begin
         case (state)
            ST_ADDR: begin
               if (scl_rise && bitcnt < 4'd8) begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end else if (scl_fall && bitcnt == 4'd8) begin
                  if (shreg == {DEV_ADDR, 1'b1}) begin
                     sda_oe <= 1'b1;
                     state  <= ST_ADDR_ACK;
                  end else begin
                     state  <= ST_IDLE;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (scl_fall) begin
                  shreg  <= {tx_byte[6:0], 1'b0};
                  sda_oe <= ~tx_byte[7];
                  bitcnt <= '0;
                  state  <= ST_TX;
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bitcnt == 4'd7) begin
                     sda_oe <= 1'b0;
                     state  <= ST_TX_ACK;
                  end else begin
                     sda_oe <= ~shreg[7];
                     shreg  <= {shreg[6:0], 1'b0};
                     bitcnt <= bitcnt + 4'd1;
                  end
               end
            end
            ST_TX_ACK: begin
               if (scl_rise) begin
                  acked <= ~sda_s;
               end else if (scl_fall) begin
                  if (acked) begin
                     shreg  <= {tx_byte[6:0], 1'b0};
                     sda_oe <= ~tx_byte[7];
                     bitcnt <= '0;
                     state  <= ST_TX;
                  end else begin
                     state  <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2c_status_reader.sv
module i2c_status_reader
   import i2cr_pkg::*;
#(
   parameter int         NUM_REGS    = 16,
   parameter logic [6:0] DEV_ADDR    = 7'h3C,
   parameter int         SYNC_STAGES = 2,
   localparam int        PTR_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int        BANK_W      = BYTE_W * NUM_REGS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [BANK_W-1:0] reg_bank_i,
   output logic              sda_oe
);
   generate
      if (NUM_REGS < 1 || NUM_REGS > 16) begin : g_bad_regs
         $error("i2c_status_reader: NUM_REGS must lie in 1..16");
      end
   endgenerate

   logic        scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic        ptr_inc;
   logic [PTR_W-1:0] ptr;
   logic [7:0]  tx_byte;
   i2cr_state_t state;

   i2cr_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_linemon (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2cr_ptr #(.NUM_REGS(NUM_REGS)) u_ptr (
      .clk(clk), .rst_n(rst_n), .clr(start_det), .inc(ptr_inc),
      .bank(reg_bank_i), .ptr(ptr), .byte_o(tx_byte)
   );

   i2cr_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .tx_byte(tx_byte), .ptr_inc(ptr_inc), .sda_oe(sda_oe), .state(state)
   );
endmodule

// File: rtl/i2cr_chk.sv
module i2cr_chk
   import i2cr_pkg::*;
#(
   parameter int  NUM_REGS = 16,
   localparam int PTR_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_s,
   input logic             start_det,
   input logic             stop_det,
   input logic [PTR_W-1:0] ptr,
   input logic             sda_oe,
   input i2cr_state_t      state
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

   AST_START_CLEARS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (ptr == '0) && !sda_oe); // R1
   AST_QUIET_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR) |-> !sda_oe); // R2
   AST_QUIET_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe); // R7
   AST_PTR_HOLDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr == LAST) && !start_det |=> (ptr == LAST)); // R8
   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe); // R9
   AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s); // R10
endmodule

bind i2c_status_reader i2cr_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
   .stop_det(stop_det), .ptr(ptr), .sda_oe(sda_oe), .state(state)
);

// File: tb/tb_i2c_status_reader.sv
module tb_i2c_status_reader;
   localparam int         NREG = 16;
   localparam logic [6:0] DEV  = 7'h3C;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic [8*NREG-1:0] bank;
   logic sda_oe;
   logic sda_line;

   int nchk = 0;
   int nerr = 0;
   int scl_hi_cnt = 0;
   logic prev_oe = 1'b0;
   logic mon_on = 1'b0;

   always #2 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   i2c_status_reader #(.NUM_REGS(NREG), .DEV_ADDR(DEV), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .reg_bank_i(bank), .sda_oe(sda_oe)
   );

   function automatic logic [7:0] exp_reg(int k);
      int idx = (k > NREG - 1) ? NREG - 1 : k;
      return bank[idx*8 +: 8];
   endfunction

   task automatic chk(logic act, logic exp, string tag);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // Per-clock reference: while SCL has been high for a while, sda_oe must hold (R10).
   always @(negedge clk) begin
      if (mon_on && scl_m && scl_hi_cnt >= 6) chk(sda_oe, prev_oe, "R10 oe moved while SCL high");
      scl_hi_cnt = scl_m ? scl_hi_cnt + 1 : 0;
      prev_oe = sda_oe;
   end

   task automatic wclk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_cycle(logic mval, logic exp_oe, string tag);
      sda_m = mval;
      wclk(8);
      scl_m = 1'b1;
      wclk(8);
      chk(sda_oe, exp_oe, tag);
      wclk(8);
      scl_m = 1'b0;
      wclk(8);
   endtask

   task automatic do_start();
      sda_m = 1'b1; wclk(8);
      scl_m = 1'b1; wclk(16);
      sda_m = 1'b0; wclk(16);
      scl_m = 1'b0; wclk(8);
   endtask

   task automatic do_stop();
      sda_m = 1'b0; wclk(8);
      scl_m = 1'b1; wclk(16);
      sda_m = 1'b1; wclk(16);
   endtask

   task automatic send_addr(logic [7:0] b, logic exp_ack, string tag);
      for (int i = 7; i >= 0; i--) bit_cycle(b[i], 1'b0, {tag, " R2 addr bit quiet"});
      bit_cycle(1'b1, exp_ack, {tag, " address acknowledge"});
   endtask

   task automatic read_byte(int k, logic ack, string tag);
      logic [7:0] b = exp_reg(k);
      for (int i = 7; i >= 0; i--) bit_cycle(1'b1, ~b[i], {tag, " R5 data bit"});
      bit_cycle(ack ? 1'b0 : 1'b1, 1'b0, {tag, " master ack slot"});
   endtask

   task automatic idle_bits(int n, string tag);
      for (int i = 0; i < n; i++) bit_cycle(1'b1, 1'b0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
      $finish;
   end

   initial begin
      for (int k = 0; k < NREG; k++) bank[k*8 +: 8] = 8'hA5 ^ 8'(k * 59);
      wclk(10);
      chk(sda_oe, 1'b0, "R11 reset state");
      rst_n = 1'b1;
      wclk(10);
      chk(sda_oe, 1'b0, "R11 after reset release");
      mon_on = 1'b1;

      // R3 R5 R6 R7: three bytes, the third not acknowledged
      do_start();
      send_addr({DEV, 1'b1}, 1'b1, "R3 match");
      read_byte(0, 1'b1, "R6 reg0");
      read_byte(1, 1'b1, "R6 reg1");
      read_byte(2, 1'b0, "R7 reg2");
      idle_bits(9, "R7 released after NAK");
      do_stop();

      // R4: wrong address, then right address with write bit
      do_start();
      send_addr({7'h3D, 1'b1}, 1'b0, "R4 wrong addr");
      idle_bits(9, "R4 ignored after mismatch");
      do_stop();
      do_start();
      send_addr({DEV, 1'b0}, 1'b0, "R4 write bit");
      idle_bits(9, "R4 ignored after write");
      do_stop();

      // R8: eighteen bytes, last three repeat register 15
      do_start();
      send_addr({DEV, 1'b1}, 1'b1, "R8 match");
      for (int k = 0; k < 18; k++) read_byte(k, (k != 17), "R8 sweep");
      do_stop();

      // R1: repeated Start after two acknowledged bytes restarts at register 0
      do_start();
      send_addr({DEV, 1'b1}, 1'b1, "R1 first match");
      read_byte(0, 1'b1, "R1 pre reg0");
      read_byte(1, 1'b1, "R1 pre reg1");
      do_start();
      send_addr({DEV, 1'b1}, 1'b1, "R1 repeated start match");
      read_byte(0, 1'b0, "R1 restart reg0");
      do_stop();

      // R9: Stop while the target is mid-byte
      do_start();
      send_addr({DEV, 1'b1}, 1'b1, "R9 match");
      do_stop();
      wclk(4);
      chk(sda_oe, 1'b0, "R9 released by stop");
      scl_m = 1'b0; wclk(8);
      idle_bits(9, "R9 idle after stop");
      do_stop();

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule